// File: doc/BRIEF.md
# Programmable-Base I/O Port Slave for an 8080-Style Bus

This block lets a chip answer I/O cycles on an 8080-style microprocessor bus as a small peripheral. It watches the low eight address lines, the active-low I/O request, the active-low read and write strobes, and an active-high cycle-qualifier input. It compares the address with an 8-bit base that the system side programs, and recognises three consecutive ports above that base. A bus write turns into a one-cycle push pulse, with the written byte, toward an outbound mailbox. A bus read turns into a one-cycle pop pulse toward an inbound mailbox. The byte that is read is returned on the data output. A direction output steers an external bidirectional transceiver.

The bus strobes are asynchronous to the block clock, so they pass through a synchronizer. Every bus access gives exactly one pulse, however long the strobe is held. Read data is captured when the access is detected and held for the rest of the cycle, so the pop that follows cannot change what the bus sees. No wait states are inserted.

Top module: `zio_bus_slave`

## Requirements
- R1: The base register resets to RESET_BASE (default 0x10). When `cfg_we` is high at a clock edge, it loads `cfg_wdata`, and the new value shows on `base_q` after that edge.
- R2: A claimed write to address base+0 raises `push_data` for exactly one cycle, three clock edges after the strobe falls. In that same cycle `push_wdata` equals the byte on `bus_din`.
- R3: A claimed write to address base+1 raises `push_ctrl` for exactly one cycle and carries the written byte on `push_wdata`.
- R4: A claimed read of address base+0 raises `pop_data` for one cycle and drives `bus_dout` with the value of `in_data` captured before the pop. That value stays stable while `bus_dir` is high, even if `in_data` changes.
- R5: A claimed read of address base+1 raises `pop_ctrl` for one cycle and returns the captured `in_ctrl` value.
- R6: A claimed read of address base+2 returns `status_in` and raises no push or pop pulse.
- R7: An access is claimed only while `iorq_n` is low and `cyc_qual` is high. A strobe without both gives no pulse and leaves `bus_dir` low.
- R8: `bus_dir` is high only during a claimed read of base+0, base+1 or base+2. It rises on the same edge as the pulse and falls three edges after the read strobe rises. `bus_dout` is zero whenever `bus_dir` is low.
- R9: A write to base+2, and any access to an address outside base+0 to base+2, gives no pulse and leaves `bus_dir` low.
- R10: A single strobe gives at most one pulse, however long it is held. At most one of the four pulses is high in any cycle.
- R11: Port offsets wrap modulo 256. With base 0xFF, address 0x00 is the control port and address 0x01 is the status port.
- R12: Synchronous reset clears every pulse, `bus_dir` and `bus_dout`. This holds even when reset arrives in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load enable for the base register |
| cfg_wdata | input | 8 | New base address |
| base_q | output | 8 | Current base address |
| bus_addr | input | 8 | Low eight bits of the bus address |
| bus_din | input | 8 | Bus data written by the processor |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| cyc_qual | input | 1 | Active-high cycle qualifier |
| bus_dout | output | 8 | Data returned to the bus during a read |
| bus_dir | output | 1 | High while the block drives the data bus |
| in_data | input | 8 | Head of the inbound data mailbox |
| in_ctrl | input | 8 | Head of the inbound control mailbox |
| status_in | input | 8 | Status byte from the mailbox core |
| push_data | output | 1 | One-cycle push into the outbound data mailbox |
| push_ctrl | output | 1 | One-cycle push into the outbound control mailbox |
| push_wdata | output | 8 | Byte carried by a push |
| pop_data | output | 1 | One-cycle pop of the inbound data mailbox |
| pop_ctrl | output | 1 | One-cycle pop of the inbound control mailbox |

## Verification
A falling strobe driven at a negative edge shows up as a pulse, together with the rise of `bus_dir` on a read, after the third rising edge. `bus_dir` falls after the third rising edge that follows the strobe's release. A base-register write is visible after one edge. The bench samples 1 ns after each rising edge and, for every access, records the index of the edge after which the first pulse appears. It counts each pulse type and the cycles with `bus_dir` high over a window that runs five edges past the release. So the checks cover the exact latency, the one-pulse rule and the drive length, not only whether something happened. The inbound mailbox values are changed right after a pop is seen, which shows whether the returned byte was captured before the pop.

// File: rtl/zio_pkg.sv
package zio_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_STAT = 2'd2,
    PORT_NONE = 2'd3
  } port_sel_t;

  localparam int NUM_PORTS = 3;
endpackage

// File: rtl/zio_sync.sv
module zio_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/zio_decode.sv
module zio_decode
  import zio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output port_sel_t     sel
);
  logic [AW-1:0] offset;

  always_comb begin
    offset = addr - base;
    unique case (offset)
      AW'(0):  sel = PORT_DATA;
      AW'(1):  sel = PORT_CTRL;
      AW'(2):  sel = PORT_STAT;
      default: sel = PORT_NONE;
    endcase
  end
endmodule

// File: rtl/zio_access.sv
module zio_access
  import zio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          wr_req,
  input  port_sel_t     sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] in_ctrl,
  input  logic [DW-1:0] status_in,
  output logic          push_data,
  output logic          push_ctrl,
  output logic          pop_data,
  output logic          pop_ctrl,
  output logic [DW-1:0] push_wdata,
  output logic          bus_dir,
  output logic [DW-1:0] bus_dout
);
  logic rd_q, wr_q;
  logic rd_rise, wr_rise;
  logic [DW-1:0] rd_mux;

  assign rd_rise = rd_req & ~rd_q;
  assign wr_rise = wr_req & ~wr_q;

  always_comb begin
    unique case (sel)
      PORT_DATA: rd_mux = in_data;
      PORT_CTRL: rd_mux = in_ctrl;
      PORT_STAT: rd_mux = status_in;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      push_data  <= 1'b0;
      push_ctrl  <= 1'b0;
      pop_data   <= 1'b0;
      pop_ctrl   <= 1'b0;
      push_wdata <= '0;
      bus_dir    <= 1'b0;
      bus_dout   <= '0;
    end else begin
      rd_q      <= rd_req;
      wr_q      <= wr_req;
      push_data <= wr_rise && (sel == PORT_DATA);
      push_ctrl <= wr_rise && (sel == PORT_CTRL);
      pop_data  <= rd_rise && (sel == PORT_DATA);
      pop_ctrl  <= rd_rise && (sel == PORT_CTRL);
      if (wr_rise) push_wdata <= wdata;
      bus_dir   <= rd_req;
      if (rd_rise)      bus_dout <= rd_mux;
      else if (!rd_req) bus_dout <= '0;
    end
  end
endmodule

// File: rtl/zio_bus_slave.sv
module zio_bus_slave
  import zio_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] RESET_BASE = 8'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_q,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cyc_qual,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dir,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] in_ctrl,
  input  logic [DW-1:0] status_in,
  output logic          push_data,
  output logic          push_ctrl,
  output logic [DW-1:0] push_wdata,
  output logic          pop_data,
  output logic          pop_ctrl
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_IDLE = 4'b1110;

  logic [NSYNC-1:0] raw_ctl, sync_ctl;
  logic iorq_s, rd_s, wr_s, qual_s;
  logic claim, rd_req, wr_req;
  port_sel_t sel;

  always_ff @(posedge clk) begin
    if (rst)         base_q <= RESET_BASE;
    else if (cfg_we) base_q <= cfg_wdata;
  end

  assign raw_ctl = {iorq_n, rd_n, wr_n, cyc_qual};

  zio_sync #(
    .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_ctl), .q(sync_ctl)
  );

  assign {iorq_s, rd_s, wr_s, qual_s} = sync_ctl;

  zio_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .base(base_q), .sel(sel)
  );

  assign claim  = ~iorq_s & qual_s;
  assign rd_req = claim & ~rd_s & wr_s & (sel != PORT_NONE);
  assign wr_req = claim & ~wr_s & rd_s & ((sel == PORT_DATA) || (sel == PORT_CTRL));

  zio_access #(.DW(DW)) u_acc (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .wr_req(wr_req), .sel(sel), .wdata(bus_din),
    .in_data(in_data), .in_ctrl(in_ctrl), .status_in(status_in),
    .push_data(push_data), .push_ctrl(push_ctrl),
    .pop_data(pop_data), .pop_ctrl(pop_ctrl),
    .push_wdata(push_wdata), .bus_dir(bus_dir), .bus_dout(bus_dout)
  );
endmodule

// File: rtl/zio_bus_slave_chk.sv
module zio_bus_slave_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] base_q,
  input logic          bus_dir,
  input logic [DW-1:0] bus_dout,
  input logic          push_data,
  input logic          push_ctrl,
  input logic          pop_data,
  input logic          pop_ctrl
);
  a_r1_base_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> base_q == $past(cfg_wdata));

  a_r4_dout_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_dir && $past(bus_dir)) |-> $stable(bus_dout));

  a_r4_pop_drives: assert property (@(posedge clk) disable iff (rst)
    (pop_data || pop_ctrl) |-> bus_dir);

  a_r8_quiet_dout: assert property (@(posedge clk) disable iff (rst)
    !bus_dir |-> bus_dout == '0);

  a_r8_no_push_while_driving: assert property (@(posedge clk) disable iff (rst)
    (push_data || push_ctrl) |-> !bus_dir);

  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_data, push_ctrl, pop_data, pop_ctrl}));

  a_r10_push_single: assert property (@(posedge clk) disable iff (rst)
    (push_data || push_ctrl) |=> !(push_data || push_ctrl));

  a_r10_pop_single: assert property (@(posedge clk) disable iff (rst)
    (pop_data || pop_ctrl) |=> !(pop_data || pop_ctrl));

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!bus_dir && bus_dout == '0 && !push_data && !push_ctrl && !pop_data && !pop_ctrl));
endmodule

bind zio_bus_slave zio_bus_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .base_q(base_q),
  .bus_dir(bus_dir), .bus_dout(bus_dout), .push_data(push_data),
  .push_ctrl(push_ctrl), .pop_data(pop_data), .pop_ctrl(pop_ctrl)
);

// File: tb/tb_zio_bus_slave.sv
`timescale 1ns/1ps
module tb_zio_bus_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] base_q;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cyc_qual = 1'b0;
  logic [7:0] bus_dout;
  logic bus_dir;
  logic [7:0] in_data = '0, in_ctrl = '0, status_in = '0;
  logic push_data, push_ctrl, pop_data, pop_ctrl;
  logic [7:0] push_wdata;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zio_bus_slave dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .base_q(base_q),
    .bus_addr(bus_addr), .bus_din(bus_din), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .cyc_qual(cyc_qual), .bus_dout(bus_dout), .bus_dir(bus_dir),
    .in_data(in_data), .in_ctrl(in_ctrl), .status_in(status_in),
    .push_data(push_data), .push_ctrl(push_ctrl), .push_wdata(push_wdata),
    .pop_data(pop_data), .pop_ctrl(pop_ctrl)
  );

  // {addr[31:24], rd[23], iorq_n[22], qual[21], wdata[20:13],
  //  pulses[12:9] = {push_data, push_ctrl, pop_data, pop_ctrl}, dir[8], dout[7:0]}
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h40, 1'b0, 1'b0, 1'b1, 8'h11, 4'b1000, 1'b0, 8'h00},  // R2 data write
    {8'h41, 1'b0, 1'b0, 1'b1, 8'h22, 4'b0100, 1'b0, 8'h00},  // R3 control write
    {8'h40, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0010, 1'b1, 8'hA5},  // R4 data read
    {8'h41, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0001, 1'b1, 8'h3C},  // R5 control read
    {8'h42, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h81},  // R6 status read
    {8'h42, 1'b0, 1'b0, 1'b1, 8'h55, 4'b0000, 1'b0, 8'h00},  // R9 status write
    {8'h43, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0000, 1'b0, 8'h00},  // R9 above range
    {8'h3F, 1'b0, 1'b0, 1'b1, 8'h66, 4'b0000, 1'b0, 8'h00},  // R9 below range
    {8'h40, 1'b1, 1'b1, 1'b1, 8'h00, 4'b0000, 1'b0, 8'h00},  // R7 no iorq
    {8'h41, 1'b0, 1'b0, 1'b0, 8'h77, 4'b0000, 1'b0, 8'h00}   // R7 no qualifier
  };

  int cnt_pd, cnt_pc, cnt_od, cnt_oc, dir_cyc, first_pulse;
  logic [7:0] dout_seen, wdata_seen;
  bit dout_unstable;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_mailboxes();
    in_data = 8'hA5;
    in_ctrl = 8'h3C;
    status_in = 8'h81;
  endtask

  task automatic sample(input int k);
    if ((push_data || push_ctrl || pop_data || pop_ctrl) && first_pulse == 0) first_pulse = k;
    if (push_data) begin cnt_pd++; wdata_seen = push_wdata; end
    if (push_ctrl) begin cnt_pc++; wdata_seen = push_wdata; end
    if (pop_data) begin cnt_od++; in_data = 8'h00; end
    if (pop_ctrl) begin cnt_oc++; in_ctrl = 8'h00; end
    if (bus_dir) begin
      if (dir_cyc == 0) dout_seen = bus_dout;
      else if (bus_dout != dout_seen) dout_unstable = 1'b1;
      dir_cyc++;
    end
  endtask

  task automatic run_access(input logic [7:0] a, input bit rd, input bit io_n,
                            input bit q, input logic [7:0] wd, input int hold);
    cnt_pd = 0; cnt_pc = 0; cnt_od = 0; cnt_oc = 0; dir_cyc = 0; first_pulse = 0;
    dout_seen = '0; wdata_seen = '0; dout_unstable = 1'b0;
    @(negedge clk);
    bus_addr = a; bus_din = wd; iorq_n = io_n; cyc_qual = q;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    for (int k = 1; k <= hold; k++) begin @(posedge clk); #1; sample(k); end
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; iorq_n = 1'b1; cyc_qual = 1'b0;
    for (int k = hold + 1; k <= hold + 5; k++) begin @(posedge clk); #1; sample(k); end
  endtask

  task automatic set_base(input logic [7:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = b;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check(base_q == b, "R1 base load", base_q, b);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    load_mailboxes();
    repeat (3) @(posedge clk);
    #1;
    check(base_q == 8'h10, "R1 reset base", base_q, 8'h10);
    check({bus_dir, bus_dout, push_data, push_ctrl, pop_data, pop_ctrl} == '0,
          "R12 reset outputs", bus_dout, 0);
    @(negedge clk);
    rst = 1'b0;

    set_base(8'h40);

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      e = VEC[v];
      load_mailboxes();
      run_access(e[31:24], e[23], e[22], e[21], e[20:13], 6);
      check({cnt_pd == int'(e[12]), cnt_pc == int'(e[11]), cnt_od == int'(e[10]),
             cnt_oc == int'(e[9])} == 4'hF,
            $sformatf("R10 pulses vec%0d", v), {cnt_pd[3:0], cnt_pc[3:0], cnt_od[3:0], cnt_oc[3:0]},
            {3'b0, e[12], 3'b0, e[11], 3'b0, e[10], 3'b0, e[9]});
      check(dir_cyc == (e[8] ? 6 : 0), $sformatf("R8 dir cycles vec%0d", v), dir_cyc, e[8] ? 6 : 0);
      if (e[12:9] != 4'b0000)
        check(first_pulse == 3, $sformatf("R2 latency vec%0d", v), first_pulse, 3);
      if (e[8]) begin
        check(dout_seen == e[7:0], $sformatf("R4 read data vec%0d", v), dout_seen, e[7:0]);
        check(!dout_unstable, $sformatf("R4 stable data vec%0d", v), dout_unstable, 0);
      end
      if (e[12] || e[11])
        check(wdata_seen == e[20:13], $sformatf("R3 push byte vec%0d", v), wdata_seen, e[20:13]);
    end

    // R10: long strobe, one pulse
    load_mailboxes();
    run_access(8'h40, 1'b1, 1'b0, 1'b1, 8'h00, 20);
    check(cnt_od == 1, "R10 long read single pop", cnt_od, 1);
    check(dir_cyc == 20, "R8 long read dir cycles", dir_cyc, 20);
    check(!dout_unstable && dout_seen == 8'hA5, "R4 long read data", dout_seen, 8'hA5);
    run_access(8'h41, 1'b0, 1'b0, 1'b1, 8'h9E, 20);
    check(cnt_pc == 1 && wdata_seen == 8'h9E, "R10 long write single push", cnt_pc, 1);

    // R11: wrap of port offsets
    set_base(8'hFF);
    load_mailboxes();
    run_access(8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 6);
    check(cnt_oc == 1 && cnt_od == 0, "R11 wrap control pop", cnt_oc, 1);
    check(dout_seen == 8'h3C, "R11 wrap control data", dout_seen, 8'h3C);
    load_mailboxes();
    run_access(8'h01, 1'b1, 1'b0, 1'b1, 8'h00, 6);
    check(dout_seen == 8'h81 && (cnt_od + cnt_oc) == 0, "R11 wrap status", dout_seen, 8'h81);
    run_access(8'hFF, 1'b0, 1'b0, 1'b1, 8'h5A, 6);
    check(cnt_pd == 1 && wdata_seen == 8'h5A, "R11 wrap data push", wdata_seen, 8'h5A);

    // R12: reset during a read
    load_mailboxes();
    @(negedge clk);
    bus_addr = 8'h01; iorq_n = 1'b0; cyc_qual = 1'b1; rd_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(bus_dir == 1'b1, "R8 dir during read", bus_dir, 1);
    @(negedge clk);
    rst = 1'b1; rd_n = 1'b1; iorq_n = 1'b1; cyc_qual = 1'b0;
    @(posedge clk); #1;
    check(!bus_dir && bus_dout == 8'h00, "R12 mid-read reset", {bus_dir, bus_dout}, 0);
    check(base_q == 8'h10, "R12 base back to reset value", base_q, 8'h10);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(posedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule